// File: doc/BRIEF.md
# Two-Level Stream Destination Lookup

This block decides, for each packet entering a two-input, two-output packet crossbar, which output port the packet leaves on. It takes the 32-bit stream identifier from the packet header. The low 16 bits of that identifier form the destination: an upper network byte and a lower host byte. The block returns one output-port number per header. The packet datapath, the arbitration and the header extraction are not part of this block.

Routing works on two levels. A local-network register names the network this switch belongs to. When a packet's network byte matches that register, the host byte indexes a host table. Otherwise the network byte indexes a network table.

Both tables and the register are loaded through a plain settings write port (strobe, address, data):
- Addresses 0 to 255 load the network table.
- Addresses 256 to 511 load the host table.
- Address 512 loads the local-network register.

Header input and result output are valid/ready streams with a single registered result stage. A header is accepted on a clock edge where `hdr_valid` and `hdr_ready` are both high. `hdr_ready` is high whenever the result stage is empty or is being drained in that same cycle, so back-pressure on the output stalls the input. A result is held unchanged until it is taken.

Top module: `dest_route_lookup`

## Requirements
- R1: The destination is taken from `hdr_sid[15:0]`, with the network byte at bits [15:8] and the host byte at bits [7:0]. Bits [31:16] have no effect on the result.
- R2: When the network byte differs from the local-network register, the result equals network-table entry [network byte].
- R3: When the network byte equals the local-network register, the result equals host-table entry [host byte], whatever the network table holds.
- R4: A settings write to address A in 0..255 loads network-table entry A from `cfg_data[0]`. The other data bits are not stored.
- R5: A settings write to address A in 256..511 loads host-table entry A-256 from `cfg_data[0]`.
- R6: A settings write to address 512 loads the local-network register from `cfg_data[7:0]`.
- R7: Settings writes to any address above 512 change no table entry and do not change the local-network register.
- R8: Reset clears both tables and the local-network register to zero and empties the result stage. After reset, every destination routes to port 0.
- R9: A header accepted on clock edge k produces `out_valid` high with its port right after edge k. A drained stage with no new header goes invalid after the next edge.
- R10: A settings write is seen by headers accepted on the edge after the write strobe's edge. A header accepted on the same edge as the write uses the old contents.
- R11: While `out_valid` is high and `out_ready` is low, `out_port` and `out_valid` hold and `hdr_ready` is low.
- R12: Several entries may name the same port. All of them route there, with no error or conflict handling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_addr | input | 16 | Settings address |
| cfg_data | input | 32 | Settings write data |
| hdr_valid | input | 1 | Header stream valid |
| hdr_ready | output | 1 | Header stream ready |
| hdr_sid | input | 32 | Stream identifier of the header |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_port | output | 1 | Selected output port |

## Verification
The lookup is swept twice:
- Over all 256 network bytes with varied host bytes and junk upper identifier bits. This separates the network-table path from the host-table path at exactly one network value, and shows the upper bits are ignored.
- Over all 256 host bytes with the network byte pinned to the local value. This exercises every host entry.

Table contents follow an arithmetic pattern, so a wrong index, a swapped table or an aliased address gives a mismatch. A lookup issued in the same cycle as a write to its entry separates old from new contents. Moving the local register moves the host-table window. Writes above 512 with alias-shaped addresses catch decoders that wrap. A stalled output with a second header waiting exposes lost or overwritten results.

// File: rtl/route_pkg.sv
package route_pkg;

  typedef enum logic [1:0] {
    CFG_NONE  = 2'd0,
    CFG_NET   = 2'd1,
    CFG_HOST  = 2'd2,
    CFG_LOCAL = 2'd3
  } cfg_target_e;

endpackage

// File: rtl/route_cfg_decode.sv
module route_cfg_decode
  import route_pkg::*;
#(
  parameter int CFG_AW = 16,
  parameter int NET_W  = 8,
  parameter int HOST_W = 8
) (
  input  logic [CFG_AW-1:0] cfg_addr,
  output cfg_target_e       target,
  output logic [NET_W-1:0]  net_idx,
  output logic [HOST_W-1:0] host_idx
);

  localparam int HOST_BASE  = 2 ** NET_W;
  localparam int LOCAL_SLOT = HOST_BASE + 2 ** HOST_W;

  logic [CFG_AW-1:0] host_off;
  logic [CFG_AW-1:0] unused_host_off;

  assign host_off        = cfg_addr - CFG_AW'(HOST_BASE);
  assign net_idx         = cfg_addr[NET_W-1:0];
  assign host_idx        = host_off[HOST_W-1:0];
  assign unused_host_off = host_off;

  always_comb begin
    if (cfg_addr < CFG_AW'(HOST_BASE))
      target = CFG_NET;
    else if (cfg_addr < CFG_AW'(LOCAL_SLOT))
      target = CFG_HOST;
    else if (cfg_addr == CFG_AW'(LOCAL_SLOT))
      target = CFG_LOCAL;
    else
      target = CFG_NONE;
  end

endmodule

// File: rtl/route_table.sv
module route_table #(
  parameter int IDX_W  = 8,
  parameter int PORT_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [PORT_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [PORT_W-1:0] rdata
);

  localparam int DEPTH = 2 ** IDX_W;

  logic [PORT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/route_local_reg.sv
module route_local_reg #(
  parameter int NET_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [NET_W-1:0] wdata,
  output logic [NET_W-1:0] local_q
);

  always_ff @(posedge clk) begin
    if (rst)     local_q <= '0;
    else if (we) local_q <= wdata;
  end

endmodule

// File: rtl/dest_route_lookup.sv
module dest_route_lookup
  import route_pkg::*;
#(
  parameter int SID_W  = 32,
  parameter int NET_W  = 8,
  parameter int HOST_W = 8,
  parameter int PORT_W = 1,
  parameter int CFG_AW = 16,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [SID_W-1:0]  hdr_sid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_port
);

  localparam int DEST_W = NET_W + HOST_W;

  cfg_target_e       target;
  logic [NET_W-1:0]  cfg_net_idx;
  logic [HOST_W-1:0] cfg_host_idx;
  logic [NET_W-1:0]  local_q;
  logic [NET_W-1:0]  dst_net;
  logic [HOST_W-1:0] dst_host;
  logic [PORT_W-1:0] net_port;
  logic [PORT_W-1:0] host_port;
  logic [PORT_W-1:0] pick;
  logic              accept;
  logic [SID_W-1:0]  unused_sid;
  logic [CFG_DW-1:0] unused_cfg;

  assign unused_sid = hdr_sid;
  assign unused_cfg = cfg_data;

  route_cfg_decode #(
    .CFG_AW(CFG_AW), .NET_W(NET_W), .HOST_W(HOST_W)
  ) u_dec (
    .cfg_addr (cfg_addr),
    .target   (target),
    .net_idx  (cfg_net_idx),
    .host_idx (cfg_host_idx)
  );

  assign dst_net  = hdr_sid[HOST_W +: NET_W];
  assign dst_host = hdr_sid[HOST_W-1:0];

  route_table #(.IDX_W(NET_W), .PORT_W(PORT_W)) u_net_tbl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_wr && target == CFG_NET),
    .widx  (cfg_net_idx),
    .wdata (cfg_data[PORT_W-1:0]),
    .ridx  (dst_net),
    .rdata (net_port)
  );

  route_table #(.IDX_W(HOST_W), .PORT_W(PORT_W)) u_host_tbl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_wr && target == CFG_HOST),
    .widx  (cfg_host_idx),
    .wdata (cfg_data[PORT_W-1:0]),
    .ridx  (dst_host),
    .rdata (host_port)
  );

  route_local_reg #(.NET_W(NET_W)) u_local (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_wr && target == CFG_LOCAL),
    .wdata   (cfg_data[NET_W-1:0]),
    .local_q (local_q)
  );

  generate
    if (DEST_W > SID_W) begin : g_bad_width
      initial $error("destination wider than stream id");
    end
  endgenerate

  assign pick      = (dst_net == local_q) ? host_port : net_port;
  assign hdr_ready = !out_valid || out_ready;
  assign accept    = hdr_valid && hdr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_port  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_port  <= pick;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dest_route_lookup_chk.sv
module dest_route_lookup_chk #(
  parameter int PORT_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_port
);

  p_accept_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_ready) |=> out_valid);

  p_drain_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !hdr_valid) |=> !out_valid);

  p_hold_result_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port)));

  p_stall_input_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !hdr_ready);

  p_reset_empty_r8: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind dest_route_lookup dest_route_lookup_chk #(.PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_port  (out_port)
);

// File: tb/sim_dest_route_lookup.sv
`timescale 1ns/1ps
module sim_dest_route_lookup;

  localparam int LOC = 8'hA5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [31:0] hdr_sid = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [0:0]  out_port;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dest_route_lookup u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_sid(hdr_sid),
    .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port)
  );

  function automatic int netp(int n);
    return ((n * 5) >> 2) & 1;
  endfunction

  function automatic int hostp(int h);
    return ((h * 3 + 1) >> 1) & 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(int a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a[15:0]; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic lookup(logic [31:0] sid, int exp, string req);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_sid = sid;
    @(negedge clk);
    hdr_valid = 1'b0;
    check(req, int'(out_valid), 1);
    check(req, int'(out_port), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", int'(out_valid), 0);
    check("R8 reset hdr_ready", int'(hdr_ready), 1);
    rst = 1'b0;

    // R8: every destination routes to port 0 before programming
    for (int i = 0; i < 16; i++)
      lookup({16'hBEEF, 8'(i * 17), 8'(i * 29)}, 0, "R8 unprogrammed route");

    // R4 R5 R6: load tables and local net; upper data bits carry junk
    for (int n = 0; n < 256; n++)
      cfg_write(n, 32'((n << 4) | netp(n)) | 32'hF0F0_0000);
    for (int h = 0; h < 256; h++)
      cfg_write(256 + h, 32'((h << 3) | hostp(h)) | 32'h0A00_0000);
    cfg_write(512, 32'hFFFF_FF00 | LOC);

    // R2 R1 R12: sweep every network byte, varied host byte and upper bits
    for (int n = 0; n < 256; n++) begin
      int h;
      h = (n * 13 + 7) & 255;
      lookup({16'(n * 977 + 3), 8'(n), 8'(h)}, (n == LOC) ? hostp(h) : netp(n),
             (n == LOC) ? "R3 local net in sweep" : "R2 R1 R12 network sweep");
    end

    // R3 R5: every host byte under the local network
    for (int h = 0; h < 256; h++)
      lookup({16'hFFFF, 8'(LOC), 8'(h)}, hostp(h), "R3 R5 host sweep");

    // R7: writes above 512, including wrap-shaped addresses, are ignored
    cfg_write(513,  32'h0000_003C | 32'(1 - netp(1)));
    cfg_write(768,  32'h0000_0011 | 32'(1 - netp(0)));
    cfg_write(1025, 32'(1 - netp(1)));
    cfg_write(1280, 32'(1 - hostp(0)));
    cfg_write(1536, 32'h0000_0012);
    cfg_write(65535, 32'hFFFF_FFFF);
    lookup({16'h0, 8'd0, 8'd9},       netp(0),  "R7 net entry 0 kept");
    lookup({16'h0, 8'd1, 8'd9},       netp(1),  "R7 net entry 1 kept");
    lookup({16'h0, 8'(LOC), 8'd0},    hostp(0), "R7 host entry 0 kept");
    lookup({16'h0, 8'(LOC), 8'd1},    hostp(1), "R7 host entry 1 kept");
    lookup({16'h0, 8'h12, 8'd4},      netp(18), "R7 local reg kept");
    lookup({16'h0, 8'hFF, 8'd4},      netp(255),"R7 local reg kept ff");

    // R10: write and lookup on the same edge sees old data, next sees new
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 16'd7; cfg_data = 32'(1 - netp(7));
    hdr_valid = 1'b1; hdr_sid = {16'h0, 8'd7, 8'd0};
    @(negedge clk);
    cfg_wr = 1'b0; hdr_valid = 1'b0;
    check("R10 same-edge valid", int'(out_valid), 1);
    check("R10 same-edge old value", int'(out_port), netp(7));
    lookup({16'h0, 8'd7, 8'd0}, 1 - netp(7), "R10 next lookup new value");

    // R6: move local net; host window follows it
    cfg_write(512, 32'h0000_0010);
    lookup({16'h0, 8'h10, 8'd2},  hostp(2),   "R6 new local uses host table");
    lookup({16'h0, 8'h10, 8'd5},  hostp(5),   "R6 new local uses host table 5");
    lookup({16'h0, 8'(LOC), 8'd2}, netp(LOC), "R6 old local now network table");

    // R11: back-pressure holds result and stalls input
    @(negedge clk);
    out_ready = 1'b0;
    hdr_valid = 1'b1; hdr_sid = {16'h0, 8'd2, 8'd0};
    @(negedge clk);
    hdr_sid = {16'h0, 8'd6, 8'd0};
    for (int k = 0; k < 3; k++) begin
      check("R11 held valid", int'(out_valid), 1);
      check("R11 held port", int'(out_port), netp(2));
      check("R11 input stalled", int'(hdr_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R11 second header valid", int'(out_valid), 1);
    check("R11 second header port", int'(out_port), netp(6));
    @(negedge clk);
    check("R9 drained goes idle", int'(out_valid), 0);

    finish_run();
  end

endmodule